// File: doc/BRIEF.md
# Watchpoint-to-Breakpoint Generation Unit

This debug block sits between the address comparators and the exception logic of a processor core. Each cycle it receives match pulses from four instruction-fetch watchpoints and two load/store watchpoints. It decides whether any of them becomes a breakpoint request. A watchpoint can become a breakpoint in two ways. The first is directly, when its trap enable is on. The effective enable is the OR of a bit that software writes and a bit shifted in over a serial debug port. The second is through one of two 16-bit countdown counters, which fires when the count of matching events reaches zero.

An instruction-fetch breakpoint (`ibrk_req`) asks the core to break before the matching instruction executes, so that instruction is not retired. A load/store breakpoint (`lbrk_req`) asks for a break after the access completes. The address of that access is latched into `brk_addr`. The counters track only work that really executed. When a counted instruction is later flushed, the core reports it on `unret_vld`/`unret_src` and the counter steps back up. While masked mode is on and the recoverable-interrupt status is low, the counters ignore matches. All match, flush and request pins are single-cycle pulses with no handshake. The block has no back-pressure: the core must take each request in the cycle it is shown.

Top module: `wpb_unit`

## Requirements
- R1: After reset, `ibrk_req` and `lbrk_req` are 0, `brk_addr` is 0, and every readable register returns 0.
- R2: Trap-enable bit k (k=0..3 for fetch watchpoint k, k=4..5 for load/store watchpoint k-4) is the OR of the software bit and the debug-port bit. A match on an enabled watchpoint raises the request of its bus in the next cycle. A match on a disabled watchpoint raises nothing.
- R3: Reading select 0 returns the software trap enables in bits [5:0] and the active debug-port trap enables in bits [13:8]. Writing select 0 loads the software bits from bits [5:0].
- R4: While `dp_shift` is 1, the debug-port shift register takes `dp_sdi` into bit 0 and moves every bit up by one. `dp_load` copies the shift register into the active debug-port enables. Shifting alone leaves the active enables unchanged.
- R5: Counter c (c=0,1) sits at select c+1. A write loads the count from [15:0], the source from [18:16] and the enable from [19], and it clears the fired flag. A read returns the count in [15:0], the source in [18:16], the enable in [19] and the fired flag in [20]. Source 1..4 selects fetch watchpoint 0..3, source 5..6 selects load/store watchpoint 0..1, and sources 0 and 7 select nothing.
- R6: An enabled counter with a nonzero count and a clear fired flag drops by one for each match of its source. Trap enables do not affect this. A counter that is disabled, or that has no source, does not count.
- R7: When a counter steps from 1 to 0, it raises the request of its source's bus in the next cycle, once. It then holds 0 with the fired flag set until it is rewritten. A counter loaded with 0 never fires.
- R8: An `unret_vld` pulse whose `unret_src` equals the source of a counting counter raises that count by one. A match and a flush report for the same counter in one cycle leave the count unchanged.
- R9: While `mask_mode` is 1 and `ri_bit` is 0, matches do not change any counter. Breakpoints from trap enables are still raised.
- R10: When `lbrk_req` rises, `brk_addr` holds the `ls_addr` of the cycle that caused it, and `brk_addr` is readable at select 3. At all other times `brk_addr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iwp_hit | input | 4 | Fetch watchpoint match pulses |
| lwp_hit | input | 2 | Load/store watchpoint match pulses |
| ls_addr | input | 32 | Load/store address of the current cycle |
| mask_mode | input | 1 | Masked counting mode |
| ri_bit | input | 1 | Recoverable-interrupt status |
| unret_vld | input | 1 | A counted instruction was flushed |
| unret_src | input | 3 | Source code of the flushed event |
| sw_we | input | 1 | Register write strobe |
| sw_sel | input | 2 | Register select for write |
| sw_wdata | input | 32 | Register write data |
| rd_sel | input | 2 | Register select for read |
| rd_data | output | 32 | Register read data |
| dp_sdi | input | 1 | Debug-port serial trap-enable data |
| dp_shift | input | 1 | Debug-port shift enable |
| dp_load | input | 1 | Debug-port transfer strobe |
| ibrk_req | output | 1 | Fetch breakpoint request (break before, no retire) |
| lbrk_req | output | 1 | Load/store breakpoint request (break after) |
| brk_addr | output | 32 | Captured load/store breakpoint address |

## Verification
The bench drives a match and a flush report to the same counter in one cycle. A design that applies only one of them would leave the count off by one. It keeps matching a counter after it has fired and sends flushes to it. A counter that wrapped or re-armed would raise a second breakpoint or read back nonzero. It loads a counter with zero, gives a counter a null source, and clears a counter's enable, and checks that none of these count or fire. It also sends matches in masked mode with `ri_bit` low and confirms that the count freezes while trap-enable breakpoints still arrive. It checks that shifted debug bits stay inactive until the strobe, and that a later load/store match with no breakpoint leaves the captured address alone.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  // Data path width of the register access port
  localparam int DATA_W    = 32;
  // Bit offset of the debug-port enables within the trap control word
  localparam int DP_TE_OFS = 8;
  // Select code of the trap control word
  localparam int SEL_TRAP  = 0;
endpackage

// File: rtl/wpb_dport_te.sv
module wpb_dport_te #(
  parameter int N_TE = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sdi,
  input  logic            shift,
  input  logic            load,
  output logic [N_TE-1:0] te_o
);
  logic [N_TE-1:0] sr_q;
  logic [N_TE-1:0] te_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
      te_q <= '0;
    end else begin
      if (shift) sr_q <= {sr_q[N_TE-2:0], sdi};
      if (load)  te_q <= sr_q;
    end
  end

  assign te_o = te_q;
endmodule

// File: rtl/wpb_bkpt_ctr.sv
module wpb_bkpt_ctr #(
  parameter int N_IWP = 4,
  parameter int N_LWP = 2,
  parameter int CNT_W = 16,
  parameter int SRC_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CNT_W-1:0]       wr_cnt,
  input  logic [SRC_W-1:0]       wr_src,
  input  logic                   wr_ena,
  input  logic [N_IWP+N_LWP-1:0] hit_vec,
  input  logic                   cnt_allow,
  input  logic                   rb_vld,
  input  logic [SRC_W-1:0]       rb_src,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [SRC_W-1:0]       src_o,
  output logic                   en_o,
  output logic                   fired_o,
  output logic                   fire_i,
  output logic                   fire_l
);
  localparam int N_SRC = N_IWP + N_LWP;

  logic [CNT_W-1:0] cnt_q;
  logic [SRC_W-1:0] src_q;
  logic             en_q;
  logic             fired_q;
  logic             src_hit;
  logic             src_ok;
  logic             active;
  logic             dec;
  logic             inc;
  logic             fire;

  always_comb begin
    src_hit = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      if (src_q == SRC_W'(k + 1)) src_hit = hit_vec[k];
    end
  end

  assign src_ok = (src_q != '0) && (src_q <= SRC_W'(N_SRC));
  assign active = en_q && !fired_q && (cnt_q != '0) && src_ok;
  assign dec    = active && src_hit && cnt_allow;
  assign inc    = active && rb_vld && (rb_src == src_q);
  assign fire   = dec && !inc && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      src_q   <= '0;
      en_q    <= 1'b0;
      fired_q <= 1'b0;
    end else if (wr_en) begin
      cnt_q   <= wr_cnt;
      src_q   <= wr_src;
      en_q    <= wr_ena;
      fired_q <= 1'b0;
    end else if (dec && !inc) begin
      cnt_q <= cnt_q - 1'b1;
      if (fire) fired_q <= 1'b1;
    end else if (inc && !dec) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign src_o   = src_q;
  assign en_o    = en_q;
  assign fired_o = fired_q;
  assign fire_l  = fire && (src_q > SRC_W'(N_IWP));
  assign fire_i  = fire && (src_q <= SRC_W'(N_IWP));
endmodule

// File: rtl/wpb_unit.sv
module wpb_unit #(
  parameter int N_IWP  = 4,
  parameter int N_LWP  = 2,
  parameter int N_CNT  = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SRC_W  = $clog2(N_IWP + N_LWP + 1),
  parameter int SEL_W  = $clog2(N_CNT + 2)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_IWP-1:0]          iwp_hit,
  input  logic [N_LWP-1:0]          lwp_hit,
  input  logic [ADDR_W-1:0]         ls_addr,
  input  logic                      mask_mode,
  input  logic                      ri_bit,
  input  logic                      unret_vld,
  input  logic [SRC_W-1:0]          unret_src,
  input  logic                      sw_we,
  input  logic [SEL_W-1:0]          sw_sel,
  input  logic [wpb_pkg::DATA_W-1:0] sw_wdata,
  input  logic [SEL_W-1:0]          rd_sel,
  output logic [wpb_pkg::DATA_W-1:0] rd_data,
  input  logic                      dp_sdi,
  input  logic                      dp_shift,
  input  logic                      dp_load,
  output logic                      ibrk_req,
  output logic                      lbrk_req,
  output logic [ADDR_W-1:0]         brk_addr
);
  import wpb_pkg::*;

  localparam int N_TE    = N_IWP + N_LWP;
  localparam int EN_BIT  = CNT_W + SRC_W;
  localparam int FIR_BIT = CNT_W + SRC_W + 1;
  localparam int SEL_BAR = N_CNT + 1;

  logic [N_TE-1:0]        sw_te_q;
  logic [N_TE-1:0]        dp_te;
  logic [N_TE-1:0]        eff_te;
  logic [N_TE-1:0]        hit_all;
  logic                   cnt_allow;
  logic [CNT_W-1:0]       cnt_a   [N_CNT];
  logic [SRC_W-1:0]       src_a   [N_CNT];
  logic [N_CNT-1:0]       en_vec;
  logic [N_CNT-1:0]       fired_vec;
  logic [N_CNT-1:0]       fire_i_vec;
  logic [N_CNT-1:0]       fire_l_vec;
  logic [N_CNT*CNT_W-1:0] cnt_flat;
  logic                   i_next;
  logic                   l_next;
  logic                   unused_wd;

  assign unused_wd = ^sw_wdata;
  assign hit_all   = {lwp_hit, iwp_hit};
  assign eff_te    = sw_te_q | dp_te;
  assign cnt_allow = !(mask_mode && !ri_bit);

  // Debug-port serial enables
  wpb_dport_te #(.N_TE(N_TE)) u_dport (
    .clk   (clk),
    .rst_n (rst_n),
    .sdi   (dp_sdi),
    .shift (dp_shift),
    .load  (dp_load),
    .te_o  (dp_te)
  );

  // Software trap enables
  always_ff @(posedge clk) begin
    if (!rst_n) sw_te_q <= '0;
    else if (sw_we && (sw_sel == SEL_W'(SEL_TRAP))) sw_te_q <= sw_wdata[N_TE-1:0];
  end

  // Countdown counters
  for (genvar c = 0; c < N_CNT; c++) begin : g_ctr
    logic wr_this;
    assign wr_this = sw_we && (sw_sel == SEL_W'(c + 1));

    wpb_bkpt_ctr #(
      .N_IWP (N_IWP),
      .N_LWP (N_LWP),
      .CNT_W (CNT_W),
      .SRC_W (SRC_W)
    ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_this),
      .wr_cnt    (sw_wdata[CNT_W-1:0]),
      .wr_src    (sw_wdata[CNT_W +: SRC_W]),
      .wr_ena    (sw_wdata[EN_BIT]),
      .hit_vec   (hit_all),
      .cnt_allow (cnt_allow),
      .rb_vld    (unret_vld),
      .rb_src    (unret_src),
      .cnt_o     (cnt_a[c]),
      .src_o     (src_a[c]),
      .en_o      (en_vec[c]),
      .fired_o   (fired_vec[c]),
      .fire_i    (fire_i_vec[c]),
      .fire_l    (fire_l_vec[c])
    );

    assign cnt_flat[c*CNT_W +: CNT_W] = cnt_a[c];
  end

  // Request merge
  assign i_next = (|(iwp_hit & eff_te[N_IWP-1:0])) || (|fire_i_vec);
  assign l_next = (|(lwp_hit & eff_te[N_TE-1:N_IWP])) || (|fire_l_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibrk_req <= 1'b0;
      lbrk_req <= 1'b0;
      brk_addr <= '0;
    end else begin
      ibrk_req <= i_next;
      lbrk_req <= l_next;
      if (l_next) brk_addr <= ls_addr;
    end
  end

  // Read path
  always_comb begin
    rd_data = '0;
    if (rd_sel == SEL_W'(SEL_TRAP)) begin
      rd_data[N_TE-1:0]          = sw_te_q;
      rd_data[DP_TE_OFS +: N_TE] = dp_te;
    end
    for (int c = 0; c < N_CNT; c++) begin
      if (rd_sel == SEL_W'(c + 1)) begin
        rd_data[CNT_W-1:0]     = cnt_a[c];
        rd_data[CNT_W +: SRC_W] = src_a[c];
        rd_data[EN_BIT]        = en_vec[c];
        rd_data[FIR_BIT]       = fired_vec[c];
      end
    end
    if (rd_sel == SEL_W'(SEL_BAR)) rd_data[ADDR_W-1:0] = brk_addr;
  end
endmodule

// File: rtl/wpb_unit_chk.sv
module wpb_unit_chk #(
  parameter int N_IWP  = 4,
  parameter int N_LWP  = 2,
  parameter int N_CNT  = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_IWP-1:0]         iwp_hit,
  input logic [N_LWP-1:0]         lwp_hit,
  input logic [ADDR_W-1:0]        ls_addr,
  input logic                     mask_mode,
  input logic                     ri_bit,
  input logic                     unret_vld,
  input logic                     sw_we,
  input logic [N_IWP+N_LWP-1:0]   eff_te,
  input logic [N_CNT*CNT_W-1:0]   cnt_flat,
  input logic [N_CNT-1:0]         fired_vec,
  input logic                     ibrk_req,
  input logic                     lbrk_req,
  input logic [ADDR_W-1:0]        brk_addr
);
  AST_TE_IBUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(iwp_hit & eff_te[N_IWP-1:0])) |=> ibrk_req); // R2
  AST_TE_LBUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lwp_hit & eff_te[N_IWP+N_LWP-1:N_IWP])) |=> lbrk_req); // R2
  AST_IREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibrk_req) |-> $past(|iwp_hit)); // R7
  AST_LREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lbrk_req) |-> $past(|lwp_hit)); // R7
  AST_BAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    lbrk_req |-> (brk_addr == $past(ls_addr))); // R10
  AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lbrk_req |-> $stable(brk_addr)); // R10

  for (genvar c = 0; c < N_CNT; c++) begin : g_cc
    AST_FIRED_STICK: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_vec[c] && !sw_we) |=> (fired_vec[c] && (cnt_flat[c*CNT_W +: CNT_W] == '0))); // R7
    AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_mode && !ri_bit && !unret_vld && !sw_we) |=> $stable(cnt_flat[c*CNT_W +: CNT_W])); // R9
  end
endmodule

bind wpb_unit wpb_unit_chk #(
  .N_IWP  (N_IWP),
  .N_LWP  (N_LWP),
  .N_CNT  (N_CNT),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iwp_hit   (iwp_hit),
  .lwp_hit   (lwp_hit),
  .ls_addr   (ls_addr),
  .mask_mode (mask_mode),
  .ri_bit    (ri_bit),
  .unret_vld (unret_vld),
  .sw_we     (sw_we),
  .eff_te    (eff_te),
  .cnt_flat  (cnt_flat),
  .fired_vec (fired_vec),
  .ibrk_req  (ibrk_req),
  .lbrk_req  (lbrk_req),
  .brk_addr  (brk_addr)
);

// File: tb/sim_wpb_unit.sv
module sim_wpb_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  iwp_hit = '0;
  logic [1:0]  lwp_hit = '0;
  logic [31:0] ls_addr = '0;
  logic        mask_mode = 1'b0;
  logic        ri_bit = 1'b1;
  logic        unret_vld = 1'b0;
  logic [2:0]  unret_src = '0;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_sel = '0;
  logic [31:0] sw_wdata = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        dp_sdi = 1'b0;
  logic        dp_shift = 1'b0;
  logic        dp_load = 1'b0;
  logic        ibrk_req;
  logic        lbrk_req;
  logic [31:0] brk_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_bar = '0;

  typedef struct {
    bit          i;
    bit          l;
    logic [31:0] a;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  wpb_unit u0 (
    .clk(clk), .rst_n(rst_n), .iwp_hit(iwp_hit), .lwp_hit(lwp_hit),
    .ls_addr(ls_addr), .mask_mode(mask_mode), .ri_bit(ri_bit),
    .unret_vld(unret_vld), .unret_src(unret_src), .sw_we(sw_we),
    .sw_sel(sw_sel), .sw_wdata(sw_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .dp_sdi(dp_sdi), .dp_shift(dp_shift), .dp_load(dp_load),
    .ibrk_req(ibrk_req), .lbrk_req(lbrk_req), .brk_addr(brk_addr)
  );

  // Monitor: compare one expected item per edge
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (ibrk_req !== e.i || lbrk_req !== e.l || brk_addr !== e.a) begin
        n_bad++;
        $display("FAIL %s: ibrk=%0b lbrk=%0b addr=%h, expected ibrk=%0b lbrk=%0b addr=%h",
                 e.tag, ibrk_req, lbrk_req, brk_addr, e.i, e.l, e.a);
      end
    end
  end

  // Driver step: push expectation, let one edge pass, clear pulses
  task automatic tick(bit ei, bit el, string tag);
    exp_t e;
    e.i = ei; e.l = el; e.a = exp_bar; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    iwp_hit = '0; lwp_hit = '0; unret_vld = 1'b0; sw_we = 1'b0;
    dp_shift = 1'b0; dp_load = 1'b0;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d, string tag);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
    tick(1'b0, 1'b0, tag);
  endtask

  task automatic rd_chk(logic [1:0] sel, logic [31:0] exp, string tag);
    rd_sel = sel;
    #2;
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd[%0d]=%h, expected %h", tag, sel, rd_data, exp);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(2'd0, 32'h0, "R1");
    rd_chk(2'd1, 32'h0, "R1");
    rd_chk(2'd2, 32'h0, "R1");
    rd_chk(2'd3, 32'h0, "R1");
    tick(1'b0, 1'b0, "R1");
    // R2 disabled watchpoint gives nothing
    iwp_hit = 4'b0010;
    tick(1'b0, 1'b0, "R2 disabled");
    // R3 software enable for fetch watchpoint 1
    wr(2'd0, 32'h0000_0002, "R3 write");
    rd_chk(2'd0, 32'h0000_0002, "R3");
    iwp_hit = 4'b0010;
    tick(1'b1, 1'b0, "R2 sw enable");
    iwp_hit = 4'b0001;
    tick(1'b0, 1'b0, "R2 other wp");
    // R4 shift in enable for load/store watchpoint 1 (bit 5)
    for (int b = 5; b >= 0; b--) begin
      dp_shift = 1'b1; dp_sdi = (b == 5);
      tick(1'b0, 1'b0, "R4 shift");
    end
    rd_chk(2'd0, 32'h0000_0002, "R4 no load yet");
    dp_load = 1'b1;
    tick(1'b0, 1'b0, "R4 load");
    rd_chk(2'd0, 32'h0000_2002, "R3 R4 readback");
    lwp_hit = 2'b10; ls_addr = 32'h1234_5678; exp_bar = 32'h1234_5678;
    tick(1'b0, 1'b1, "R2 R10 dp enable");
    lwp_hit = 2'b01; ls_addr = 32'h0000_DEAD;
    tick(1'b0, 1'b0, "R10 hold");
    rd_chk(2'd3, 32'h1234_5678, "R10 readback");
    // Counter 0 on fetch watchpoint 0, count 3
    wr(2'd1, 32'h0009_0003, "R5 write");
    rd_chk(2'd1, 32'h0009_0003, "R5");
    iwp_hit = 4'b0001;
    tick(1'b0, 1'b0, "R6 count");
    rd_chk(2'd1, 32'h0009_0002, "R6");
    unret_vld = 1'b1; unret_src = 3'd1;
    tick(1'b0, 1'b0, "R8 rollback");
    rd_chk(2'd1, 32'h0009_0003, "R8 rollback");
    iwp_hit = 4'b0001; unret_vld = 1'b1; unret_src = 3'd1;
    tick(1'b0, 1'b0, "R8 both");
    rd_chk(2'd1, 32'h0009_0003, "R8 both");
    iwp_hit = 4'b0001; tick(1'b0, 1'b0, "R6");
    iwp_hit = 4'b0001; tick(1'b0, 1'b0, "R6");
    iwp_hit = 4'b0001; tick(1'b1, 1'b0, "R7 fire");
    rd_chk(2'd1, 32'h0019_0000, "R7 fired");
    iwp_hit = 4'b0001; tick(1'b0, 1'b0, "R7 no refire");
    unret_vld = 1'b1; unret_src = 3'd1;
    tick(1'b0, 1'b0, "R7 flush after fire");
    rd_chk(2'd1, 32'h0019_0000, "R7 hold");
    // Counter 1 on load/store watchpoint 0, count 2, masked mode
    wr(2'd2, 32'h000D_0002, "R5 write");
    mask_mode = 1'b1; ri_bit = 1'b0;
    lwp_hit = 2'b01; ls_addr = 32'hAAAA_0000;
    tick(1'b0, 1'b0, "R9 masked");
    rd_chk(2'd2, 32'h000D_0002, "R9 frozen");
    ri_bit = 1'b1;
    lwp_hit = 2'b01;
    tick(1'b0, 1'b0, "R9 ri set");
    rd_chk(2'd2, 32'h000D_0001, "R9 counts");
    ri_bit = 1'b0;
    iwp_hit = 4'b0010;
    tick(1'b1, 1'b0, "R9 trap still");
    mask_mode = 1'b0; ri_bit = 1'b1;
    lwp_hit = 2'b01; ls_addr = 32'hBBBB_0000; exp_bar = 32'hBBBB_0000;
    tick(1'b0, 1'b1, "R7 R10 l fire");
    rd_chk(2'd2, 32'h001D_0000, "R7 l fired");
    rd_chk(2'd3, 32'hBBBB_0000, "R10");
    // Counter loaded with zero
    wr(2'd2, 32'h000D_0000, "R7 zero load");
    rd_chk(2'd2, 32'h000D_0000, "R5 rewrite clears flag");
    lwp_hit = 2'b01; ls_addr = 32'hCCCC_0000;
    tick(1'b0, 1'b0, "R7 zero never fires");
    rd_chk(2'd2, 32'h000D_0000, "R7 zero");
    // Null source and disabled counter
    wr(2'd1, 32'h0008_0005, "R5 null src");
    iwp_hit = 4'b0001;
    tick(1'b0, 1'b0, "R5 null src");
    rd_chk(2'd1, 32'h0008_0005, "R5 null src");
    wr(2'd1, 32'h0001_0005, "R6 disabled");
    iwp_hit = 4'b0001;
    tick(1'b0, 1'b0, "R6 disabled");
    rd_chk(2'd1, 32'h0001_0005, "R6 disabled");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule